// File: doc/BRIEF.md
# Infrared Transceiver Bandwidth-Mode Sequencer

This block owns the shutdown and transmit-data lines of an infrared transceiver. On request it plays the timed waveform that moves the transceiver between its low-bandwidth mode and its high-bandwidth mode. The low-bandwidth mode carries rates up to 115.2 kbit/s. The high-bandwidth mode carries 0.576 to 4 Mbit/s.

The transceiver latches the level on its transmit-data line at the falling edge of its shutdown line, and that level selects the speed. For this reason the block holds the data line steady for a minimum time before that edge and for a minimum time after it. Both minimum times are given in picoseconds and converted to a whole number of clock cycles, rounded up. Once the waveform is complete, the serial transmitter regains the data line through a mux, and the block reports the newly programmed mode.

The host requests a switch by setting `mode_req_i` and pulsing `start_i` while `ready_o` is high. The block drops `ready_o` while it works. When it finishes, it raises `done_o` for one cycle, and in that same cycle `mode_o` takes the new value.

Top module: `irx_mode_seq`

## Requirements
- R1: After reset, `mode_o` is 0 (low-bandwidth), `sd_o` is 0, `ready_o` is 1 and `done_o` is 0.
- R2: While idle, `sd_o` is 0 and `txd_o` equals `ser_txd_i` in the same cycle.
- R3: In the cycle after a start is sampled in idle, `sd_o` is 1, `txd_o` is 0 and `ready_o` is 0. This lead phase lasts one cycle.
- R4: After the lead cycle, `sd_o` stays 1 and `txd_o` carries the requested level (1 = high-bandwidth, 0 = low-bandwidth) for SETUP_CYC = ceil(SETUP_MIN_PS / CLK_PERIOD_PS) cycles.
- R5: `sd_o` falls only after `txd_o` has been stable with `sd_o` high for at least SETUP_CYC cycles.
- R6: After `sd_o` falls, `txd_o` keeps the latched level for exactly HOLD_CYC = ceil(HOLD_MIN_PS / CLK_PERIOD_PS) cycles. After that, control of the line returns to the serial input.
- R7: While a sequence runs, `start_i`, `mode_req_i` and `ser_txd_i` have no effect on the outputs, and `ready_o` is 0.
- R8: `done_o` is high for exactly one cycle, namely the first idle cycle after the hold phase. In that cycle `ready_o` is 1 and `mode_o` equals the level that was latched.
- R9: `mode_o` changes only in a cycle where `done_o` is high.
- R10: A start sampled in the cycle where `done_o` is high is accepted and begins a new sequence.
- R11: A request for the mode that is already in effect still runs the full sequence and ends with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the programming sequence |
| mode_req_i | input | 1 | Requested mode: 1 high-bandwidth, 0 low-bandwidth |
| ser_txd_i | input | 1 | Transmit data from the serial transmitter |
| sd_o | output | 1 | Shutdown line to the transceiver |
| txd_o | output | 1 | Transmit-data line to the transceiver |
| ready_o | output | 1 | Idle and able to accept a start |
| done_o | output | 1 | One-cycle pulse when a sequence completes |
| mode_o | output | 1 | Currently programmed mode |

## Verification
The completion pulse and the acceptance of a new start can occur in the same cycle. The first idle cycle both reports `done_o` with the updated `mode_o` and samples `start_i`. The bench provokes this by raising `start_i` as soon as it sees `done_o` high, and requests the opposite mode. A per-cycle reference model then expects a lead phase to follow at once, with no extra idle cycle and no second done pulse. It also expects `mode_o` to keep the value it took in the done cycle until the next sequence completes.

// File: rtl/irx_mode_seq.sv
module irx_mode_seq #(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int SETUP_MIN_PS  = 200000,
  parameter int HOLD_MIN_PS   = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mode_req_i,
  input  logic ser_txd_i,
  output logic sd_o,
  output logic txd_o,
  output logic ready_o,
  output logic done_o,
  output logic mode_o
);

  localparam int SETUP_RAW = (SETUP_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int HOLD_RAW  = (HOLD_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int HOLD_CYC  = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int MAX_CYC   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SETUP, ST_HOLD} state_t;

  state_t           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;
  logic             done_q;
  logic             mode_q;

  wire idle     = (state_q == ST_IDLE);
  wire cnt_wrap = (state_q == ST_SETUP) ? (cnt_q == SETUP_LAST) : (cnt_q == HOLD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LEAD;
          lvl_q   <= mode_req_i;
          cnt_q   <= '0;
        end
        ST_LEAD: begin
          state_q <= ST_SETUP;
          cnt_q   <= '0;
        end
        ST_SETUP: begin
          if (cnt_wrap) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_wrap) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
            mode_q  <= lvl_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sd_o    = (state_q == ST_LEAD) || (state_q == ST_SETUP);
  assign txd_o   = idle ? ser_txd_i : ((state_q == ST_LEAD) ? 1'b0 : lvl_q);
  assign ready_o = idle;
  assign done_o  = done_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/irx_mode_seq_chk.sv
module irx_mode_seq_chk #(
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1
) (
  input logic clk,
  input logic rst_n,
  input logic ser_txd_i,
  input logic sd_o,
  input logic txd_o,
  input logic ready_o,
  input logic done_o,
  input logic mode_o
);

  logic prev_sd, prev_txd, lat, hold_ok;
  int   stab, hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sd  <= 1'b0;
      prev_txd <= 1'b0;
      lat      <= 1'b0;
      hold_ok  <= 1'b0;
      stab     <= 0;
      hcnt     <= 0;
    end else begin
      prev_sd  <= sd_o;
      prev_txd <= txd_o;
      if (!sd_o) stab <= 0;
      else if (!prev_sd || txd_o != prev_txd) stab <= 1;
      else if (stab < 1000000) stab <= stab + 1;
      if (prev_sd && !sd_o) begin
        lat     <= txd_o;
        hcnt    <= 1;
        hold_ok <= 1'b1;
      end else if (done_o) begin
        hold_ok <= 1'b0;
      end else if (hold_ok && !sd_o) begin
        if (txd_o == lat) hcnt <= hcnt + 1;
        else hold_ok <= 1'b0;
      end
    end
  end

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!sd_o && txd_o == ser_txd_i)); // R2
  AST_SETUP_MET: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_sd && !sd_o) |-> (stab >= SETUP_CYC)); // R5
  AST_HOLD_MET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (hold_ok && hcnt >= HOLD_CYC)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ready_o && mode_o == $past(txd_o))); // R8
  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(mode_o)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sd_o |-> !ready_o); // R7

endmodule

bind irx_mode_seq irx_mode_seq_chk #(
  .SETUP_CYC(SETUP_CYC),
  .HOLD_CYC (HOLD_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_txd_i(ser_txd_i),
  .sd_o     (sd_o),
  .txd_o    (txd_o),
  .ready_o  (ready_o),
  .done_o   (done_o),
  .mode_o   (mode_o)
);

// File: tb/irx_mode_seq_tb.sv
`timescale 1ns/1ps
module irx_mode_seq_tb;
  localparam int PER_PS = 4000;
  localparam int S_CYC  = (200000 + PER_PS - 1) / PER_PS;
  localparam int H_CYC  = (200000 + PER_PS - 1) / PER_PS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, mode_req_i = 1'b0, ser_txd_i = 1'b0;
  logic sd_o, txd_o, ready_o, done_o, mode_o;
  int checks = 0, fails = 0, cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irx_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_req_i(mode_req_i),
    .ser_txd_i(ser_txd_i), .sd_o(sd_o), .txd_o(txd_o), .ready_o(ready_o),
    .done_o(done_o), .mode_o(mode_o)
  );

  // reference model: phase 0 idle, 1 lead, 2 setup, 3 hold
  int ph = 0, cnt = 0;
  bit lvl = 0, m_mode = 0, m_done = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ph = 0; cnt = 0; lvl = 0; m_mode = 0; m_done = 0;
    end else begin
      m_done = 0;
      case (ph)
        0: if (start_i) begin ph = 1; lvl = mode_req_i; end
        1: begin ph = 2; cnt = 0; end
        2: begin cnt++; if (cnt == S_CYC) begin ph = 3; cnt = 0; end end
        default: begin
          cnt++;
          if (cnt == H_CYC) begin ph = 0; m_done = 1; m_mode = lvl; end
        end
      endcase
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %b expected %b at cycle %0d", req, nm, act, exp, cycles);
    end
  endtask

  // waveform monitor for setup/hold windows
  logic p_sd = 0, p_txd = 0, w_lat = 0;
  int stab = 0, hcnt = 0;
  bit in_hold = 0;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      // R2 R3 R4 R6 R7 sd/txd path, R1 R8 R9 R10 R11 status path
      chk((ph == 0) ? "R2" : (ph == 1) ? "R3" : "R4", "sd_o", sd_o, (ph == 1 || ph == 2));
      chk((ph == 0) ? "R2" : (ph == 3) ? "R6" : "R4", "txd_o", txd_o,
          (ph == 0) ? ser_txd_i : (ph == 1) ? 1'b0 : lvl);
      chk("R7", "ready_o", ready_o, ph == 0);
      chk("R8", "done_o", done_o, m_done);
      chk("R9", "mode_o", mode_o, m_mode);
      if (p_sd && !sd_o) begin
        chk("R5", "setup_ok", stab >= S_CYC, 1'b1);
        in_hold = 1; w_lat = txd_o; hcnt = 1;
      end else if (in_hold && done_o) begin
        chk("R6", "hold_ok", hcnt == H_CYC, 1'b1);
        in_hold = 0;
      end else if (in_hold && txd_o == w_lat) hcnt++;
      else in_hold = 0;
      if (!sd_o) stab = 0;
      else if (!p_sd || txd_o != p_txd) stab = 1;
      else stab++;
      p_sd = sd_o; p_txd = txd_o;
    end
  end

  // serial input wiggles throughout so ignoring it during a sequence is visible
  always @(negedge clk) ser_txd_i <= $urandom_range(0, 1);

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic run_seq(input bit req);
    @(negedge clk);
    start_i = 1; mode_req_i = req;
    @(negedge clk);
    start_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "mode_o", mode_o, 1'b0);
    chk("R1", "sd_o", sd_o, 1'b0);
    chk("R1", "ready_o", ready_o, 1'b1);
    chk("R1", "done_o", done_o, 1'b0);
    repeat (5) @(negedge clk);
    // switch to high bandwidth; extra starts mid-sequence must be ignored (R7)
    run_seq(1'b1);
    repeat (10) @(negedge clk);
    start_i = 1; mode_req_i = 0;
    repeat (3) @(negedge clk);
    start_i = 0;
    wait_done();
    // R10: start in the done cycle, back to low bandwidth
    start_i = 1; mode_req_i = 0;
    @(negedge clk);
    start_i = 0;
    wait_done();
    repeat (4) @(negedge clk);
    // R11: request the mode already in effect
    run_seq(1'b0);
    wait_done();
    // start held high across done: immediate second sequence (R10)
    @(negedge clk);
    start_i = 1; mode_req_i = 1;
    wait_done();
    mode_req_i = 1;
    @(negedge clk);
    start_i = 0;
    wait_done();
    repeat (6) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule